// File: doc/BRIEF.md
# Serial Command Interface for an Eight-Channel Switch

This block is the digital front end of an eight-channel power switch. A host talks to it over a four-wire serial link framed by an active-low chip select. While the select is active, the host shifts in an on/off command, one bit per channel. At the same time the block shifts out a snapshot of eight per-channel status flags, taken when the frame opened. When the select is released, the command word is moved into an output latch, and that latch drives the channel controls.

The link pins are not used as clocks. They are sampled by a faster system clock and then edge-detected, so every register in the block runs on one clock domain. The serial clock must therefore run at no more than a quarter of the system clock rate. The serial output keeps shifting for as long as clocks arrive. A frame longer than eight bits passes the earlier bits on to the serial output, so several devices can share one select in a chain, and the latch takes the most recent eight bits.

Top module: `octsw_serial_ctrl`

## Requirements
- R1: After reset, `ch_off` is 8'hFF (every channel off) and `sdo_oe` is 0.
- R2: When the synchronized `cs_n` falls, `status_in` is captured. Bit 7 appears on `sdo` before the first serial clock, and bits 6 down to 0 follow. Changes on `status_in` after that capture do not alter the bits read out.
- R3: The shift contents are copied into `ch_off` only when `cs_n` rises. `ch_off` holds its value for the whole of a frame.
- R4: `sdo_oe` is 1 while `cs_n` is low and 0 while it is high, so an external pad can place `sdo` in high impedance.
- R5: A serial bit of 1 sets the matching `ch_off` bit to 1 (channel off). A serial bit of 0 sets it to 0 (channel on).
- R6: The first bit of an eight-bit frame lands in `ch_off[7]` and the last bit lands in `ch_off[0]`.
- R7: `sdi` is taken on the rising edge of `sclk`, and `sdo` advances on the falling edge. A host that reads `sdo` at the end of each high phase sees one bit per clock.
- R8: Toggling `sclk` and `sdi` while `cs_n` is high changes neither `ch_off` nor the data read out in the next frame.
- R9: In a frame of more than eight clocks, clock j (counting from 0) presents received bit j-8 on `sdo` for every j of 8 or more. On release, the last eight bits received are latched.
- R10: In a frame of k clocks with k below 8, `ch_off` takes status bits 7-k down to 0 in its upper k... its upper 8-k positions, and the k received bits fill the low k positions.
- R11: The link works with an `sclk` period of four system clocks or longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all link pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Frame select from the host, active low |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial command data from the host |
| status_in | input | 8 | Per-channel status flags, captured when a frame opens |
| sdo | output | 1 | Serial data to the host, or to the next device in a chain |
| sdo_oe | output | 1 | Drive enable for the `sdo` pad |
| ch_off | output | 8 | Latched channel controls, 1 means off |

## Verification
The hardest cases to reach from the ports are frames of unusual length and a status input that moves in the middle of a frame. In those cases the latched word mixes snapshot bits with received bits, and the bits passed through the chain come from an earlier stage. The stimulus sweeps every frame length from 0 to 24 clocks. It changes `status_in` right after the first serial clock of every frame, so that only a true snapshot can give the right readout. Expected readout and latch values come from one arithmetic model: the status byte with the transmitted bits appended after it.

// File: rtl/octsw_pkg.sv
// Package: shared constants for the serial switch controller.
// Assumes: the pin-index layout below is used by every module that
// groups the edge-detected link pins into one vector.
package octsw_pkg;
    localparam int CH_COUNT    = 8;   // channels per device
    localparam int SYNC_DEPTH  = 2;   // synchronizer flops per pin
    localparam int EDGE_CS     = 0;   // index of chip select in edge vector
    localparam int EDGE_SCLK   = 1;   // index of serial clock in edge vector
    localparam int EDGE_COUNT  = 2;   // pins that need edge detection
endpackage

// File: rtl/octsw_pin_sync.sv
// Module: multi-flop synchronizer for a vector of asynchronous pins.
// Assumes: pins are quasi-static relative to clk; each bit is synchronized
// independently, and RST_VAL gives the idle level of each pin.
module octsw_pin_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], pin_i[b]};
        end

        assign lvl_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/octsw_edge_det.sv
// Module: rise/fall pulse generator for synchronized levels.
// Assumes: inputs are already synchronous to clk; pulses last one cycle and
// coincide with the first cycle the new level is visible.
module octsw_edge_det #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    // Compare current and previous levels per bit.
    always_comb begin
        rise_o = lvl_i & ~prev_q;
        fall_o = prev_q & ~lvl_i;
    end
endmodule

// File: rtl/octsw_shifter.sv
// Module: frame shift register with parallel status load.
// Assumes: event inputs are single-cycle pulses in the clk domain; the
// select edge and serial clock edges never coincide (serial clock low
// whenever the select moves). The load takes priority if they do.
module octsw_shifter #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_act_i,
    input  logic         load_i,
    input  logic [N-1:0] par_i,
    input  logic         sclk_rise_i,
    input  logic         sclk_fall_i,
    input  logic         sdi_i,
    output logic [N-1:0] shreg_o,
    output logic         si_bit_o
);
    logic [N-1:0] shreg_q;
    logic         si_q;

    // Capture the incoming data bit on a serial clock rise within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                          si_q <= 1'b0;
        else if (frame_act_i && sclk_rise_i) si_q <= sdi_i;
    end

    // Load status at frame start, otherwise shift on serial clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                          shreg_q <= '0;
        else if (load_i)                     shreg_q <= par_i;
        else if (frame_act_i && sclk_fall_i) shreg_q <= {shreg_q[N-2:0], si_q};
    end

    assign shreg_o  = shreg_q;
    assign si_bit_o = si_q;
endmodule

// File: rtl/octsw_out_latch.sv
// Module: channel control latch, updated once per frame.
// Assumes: commit_i is a single-cycle pulse at frame end; reset value
// switches every channel off (active-low command encoding).
module octsw_out_latch #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] q;

    // Hold command until the next frame commits a new one.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '1;
        else if (commit_i) q <= d_i;
    end

    assign q_o = q;
endmodule

// File: rtl/octsw_serial_ctrl.sv
// Module: top of the serial command interface for an eight-channel switch.
// Assumes: sclk runs at most at a quarter of clk; sclk is low whenever cs_n
// changes; sdo is padded externally using sdo_oe as the tri-state enable.
module octsw_serial_ctrl
    import octsw_pkg::*;
#(
    parameter int NCH    = CH_COUNT,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           sclk,
    input  logic           sdi,
    input  logic [NCH-1:0] status_in,
    output logic           sdo,
    output logic           sdo_oe,
    output logic [NCH-1:0] ch_off
);
    localparam int                NPIN     = EDGE_COUNT + 1;
    localparam logic [NPIN-1:0]   PIN_IDLE = 3'b001; // sdi, sclk low; cs_n high

    logic [NPIN-1:0]       pins_raw, pins_lvl;
    logic [EDGE_COUNT-1:0] ed_rise, ed_fall;
    logic                  cs_lvl, sdi_lvl;
    logic                  cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic [NCH-1:0]        shift_q;
    logic                  si_bit;

    assign pins_raw = {sdi, sclk, cs_n};

    octsw_pin_sync #(.W(NPIN), .STAGES(STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pins_raw),
        .lvl_o (pins_lvl)
    );

    octsw_edge_det #(.W(EDGE_COUNT), .RST_VAL(PIN_IDLE[EDGE_COUNT-1:0])) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (pins_lvl[EDGE_COUNT-1:0]),
        .rise_o (ed_rise),
        .fall_o (ed_fall)
    );

    // Name the synchronized levels and event pulses.
    always_comb begin
        cs_lvl    = pins_lvl[EDGE_CS];
        sdi_lvl   = pins_lvl[EDGE_COUNT];
        cs_fall   = ed_fall[EDGE_CS];
        cs_rise   = ed_rise[EDGE_CS];
        sclk_rise = ed_rise[EDGE_SCLK];
        sclk_fall = ed_fall[EDGE_SCLK];
    end

    octsw_shifter #(.N(NCH)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_act_i (~cs_lvl),
        .load_i      (cs_fall),
        .par_i       (status_in),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .sdi_i       (sdi_lvl),
        .shreg_o     (shift_q),
        .si_bit_o    (si_bit)
    );

    octsw_out_latch #(.N(NCH)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (cs_rise),
        .d_i      (shift_q),
        .q_o      (ch_off)
    );

    // Serial output is the far end of the shift register; enabled in frame.
    always_comb begin
        sdo    = shift_q[NCH-1];
        sdo_oe = ~cs_lvl;
    end
endmodule

// File: rtl/octsw_serial_ctrl_chk.sv
// Module: property checker for octsw_serial_ctrl, attached by bind.
// Assumes: observes synchronized events and the shift register inside the top.
module octsw_serial_ctrl_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] status_in,
    input logic           cs_lvl,
    input logic           cs_fall,
    input logic           cs_rise,
    input logic           sclk_fall,
    input logic [NCH-1:0] shift_q,
    input logic           si_bit,
    input logic [NCH-1:0] ch_off,
    input logic           sdo,
    input logic           sdo_oe
);
    p_snapshot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> shift_q == $past(status_in));

    p_first_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (sdo_oe && sdo == $past(status_in[NCH-1])));

    p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> ch_off == $past(shift_q));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(ch_off));

    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> $stable(shift_q));

    p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_fall && !cs_lvl && !cs_fall) |=>
            shift_q == {$past(shift_q[NCH-2:0]), $past(si_bit)});
endmodule

bind octsw_serial_ctrl octsw_serial_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status_in (status_in),
    .cs_lvl    (cs_lvl),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall),
    .shift_q   (shift_q),
    .si_bit    (si_bit),
    .ch_off    (ch_off),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
);

// File: tb/octsw_serial_ctrl_tb.sv
`timescale 1ns/1ps
module octsw_serial_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] status_in = 8'h00;
    logic       sdo, sdo_oe;
    logic [7:0] ch_off;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] latch_model = 8'hFF;

    always #2.5 clk = ~clk;

    octsw_serial_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .status_in(status_in), .sdo(sdo), .sdo_oe(sdo_oe), .ch_off(ch_off)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One frame: n clocks, tx bits sent from tx[n-1] down to tx[0], h = half period.
    task automatic run_frame(input logic [7:0] st, input logic [31:0] tx,
                             input int n, input int h);
        logic [63:0] cat;
        logic [7:0]  exp_latch;
        cat = ({56'd0, st} << n) | {32'd0, tx};
        exp_latch = cat[7:0];
        status_in = st;
        @(negedge clk) cs_n = 1'b0;
        repeat (2*h + 2) @(negedge clk);
        check(sdo == st[7], "R2 first status bit", sdo, st[7]);
        check(sdo_oe == 1'b1, "R4 oe in frame", sdo_oe, 1);
        for (int j = 0; j < n; j++) begin
            sdi = tx[n-1-j];
            repeat (h) @(negedge clk);
            sclk = 1'b1;
            if (j == 0) status_in = ~st;   // R2: snapshot must not follow
            repeat (h) @(negedge clk);
            check(sdo == cat[8+n-1-j], (j >= 8) ? "R9 chained bit" : "R7 readout bit",
                  sdo, cat[8+n-1-j]);
            sclk = 1'b0;
        end
        repeat (2*h + 2) @(negedge clk);
        check(ch_off == latch_model, "R3 hold during frame", ch_off, latch_model);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check(ch_off == exp_latch, (n < 8) ? "R10 short frame latch" :
              ((n > 8) ? "R9 last bits latched" : "R6 R5 latch"), ch_off, exp_latch);
        check(sdo_oe == 1'b0, "R4 oe released", sdo_oe, 0);
        latch_model = exp_latch;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ch_off == 8'hFF, "R1 latch reset", ch_off, 8'hFF);
        check(sdo_oe == 1'b0, "R1 oe reset", sdo_oe, 0);

        // R5 R6 R11: every command at the fastest allowed clock, all status values
        for (int c = 0; c < 256; c++) begin
            logic [7:0] st;
            st = {c[3:0], c[7:4]} ^ 8'hA5;
            run_frame(st, {24'd0, c[7:0]}, 8, 2);
        end
        // R5: explicit single-channel on/off encoding
        run_frame(8'h00, 32'h0000_007F, 8, 3);
        check(ch_off[7] == 1'b0 && ch_off[6:0] == 7'h7F, "R5 first bit 0 turns ch7 on",
              ch_off, 8'h7F);

        // R9 R10: frame lengths 0..24
        for (int n = 0; n <= 24; n++) begin
            run_frame(8'h3C ^ n[7:0], 32'hC6A5_1E97 >> (32 - n), n, 3);
        end

        // R8: activity while deselected is ignored
        for (int k = 0; k < 10; k++) begin
            sdi = k[0];
            repeat (3) @(negedge clk) sclk = ~sclk;
        end
        sclk = 1'b0;
        repeat (6) @(negedge clk);
        check(ch_off == latch_model, "R8 latch untouched", ch_off, latch_model);
        check(sdo_oe == 1'b0, "R8 oe stays off", sdo_oe, 0);
        run_frame(8'h96, 32'h0000_0069, 8, 5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule